// File: doc/BRIEF.md
# PLL Frequency Change Sequencer

This block steps a clock generator from one multiplier and reference divider setting to another without letting the system clock overshoot its ceiling. When the multiplier changes, the loop briefly runs fast. To absorb that overshoot, the sequencer first slows the output by writing a reference divider code one step larger than the target. It then writes the new multiplier and waits for the lock detector to report frequency lock. Only after that does it write the real divider code.

A requester places a 3-bit multiplier code and a 3-bit divider code on the request inputs and pulses `start`. The block captures both codes and runs the sequence on its own. It reports `busy` while the sequence runs, a one-cycle `done` when the final divider write completes, and a sticky `err` if lock never arrives within a programmable number of cycles.

The output frequency is f_ref × 2·(mul_code + 2) / 2^div_code. The multiplier factor is 2·(mul_code + 2) and the divider is 2^div_code. The reset codes select twice the reference frequency.

Top module: `pll_retune_seq`

## Requirements
- R1: After reset, `mul_code` is 0 and `div_code` is 1, which gives twice the reference frequency under the formula above. `busy`, `done` and `err` are all 0.
- R2: A `start` seen at a clock edge while idle captures `req_mul` and `req_div`, and `busy` is 1 from that edge on.
- R3: One edge after acceptance, `div_code` becomes the captured divider code plus one. A captured code of 7 stays at 7 and does not wrap. `mul_code` is not yet changed at this point.
- R4: On the next edge, `mul_code` becomes the captured multiplier code and `div_code` keeps the safe value.
- R5: `lock` is not looked at for SETTLE_CYC cycles after the multiplier write. If `lock` is held high throughout, the final divider write lands exactly SETTLE_CYC+2 edges after the multiplier write.
- R6: Once `lock` is seen high during monitoring, `div_code` becomes the captured divider code one edge later, and `busy` falls on that same edge. Until then, `div_code` keeps the safe value.
- R7: A `start` pulse while `busy` is 1 is ignored. The codes in flight are not replaced, and no second sequence is queued.
- R8: `done` is 1 for exactly one cycle, namely the cycle in which the final divider value first appears.
- R9: If `lock` stays low for `tmo_limit` monitored cycles, the sequence ends. `err` becomes 1, `busy` becomes 0 and `done` stays 0. `div_code` keeps the safe value and `mul_code` keeps the target. `err` clears when the next `start` is accepted. A `tmo_limit` of 0 behaves like 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, accepted only when idle |
| req_mul | input | 3 | Requested multiplier code |
| req_div | input | 3 | Requested reference divider code |
| tmo_limit | input | TMO_W | Lock wait limit in cycles |
| lock | input | 1 | Frequency lock from the lock detector |
| mul_code | output | 3 | Multiplier field driven to the PLL |
| div_code | output | 3 | Reference divider field driven to the PLL |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the final divider is written |
| err | output | 1 | Sticky lock timeout flag |

## Verification
The bench builds the block with SETTLE_CYC = 5 and TMO_W = 8. The short settle window lets the test hold `lock` high from the start and still pin the final write to an exact edge, so an early start of monitoring shows up as a wrong cycle count. The 8-bit limit lets a timeout of 6 cycles be reached quickly. A limit of 200 keeps a late-lock run well clear of the timeout.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  localparam int CODE_W = 3;
  localparam logic [CODE_W-1:0] CODE_MAX = '1;
  localparam logic [CODE_W-1:0] MUL_RST  = CODE_W'(0);
  localparam logic [CODE_W-1:0] DIV_RST  = CODE_W'(1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIV_SAFE,
    ST_MUL,
    ST_SETTLE,
    ST_WAIT,
    ST_DIV_FINAL
  } seq_state_t;

  // divider code one step slower, clamped at the top code
  function automatic logic [CODE_W-1:0] safe_div(input logic [CODE_W-1:0] d);
    return (d == CODE_MAX) ? CODE_MAX : d + CODE_W'(1);
  endfunction
endpackage

// File: rtl/pll_seq_counter.sv
module pll_seq_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (!en) cnt <= '0;
    else          cnt <= cnt + W'(1);
  end

  // hit in the cycle that completes 'limit' enabled cycles (0 acts as 1)
  assign hit = en && ((W+1)'(cnt) + (W+1)'(1) >= (W+1)'(limit));
endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
  import pll_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic lock,
  input  logic settle_hit,
  input  logic wait_hit,
  output logic settle_en,
  output logic wait_en,
  output logic ev_accept,
  output logic ev_wr_safe,
  output logic ev_wr_mul,
  output logic ev_wr_final,
  output logic ev_timeout,
  output logic busy,
  output logic done,
  output logic err
);
  seq_state_t st, st_nx;

  assign busy        = (st != ST_IDLE);
  assign ev_accept   = (st == ST_IDLE) && start;
  assign ev_wr_safe  = (st == ST_DIV_SAFE);
  assign ev_wr_mul   = (st == ST_MUL);
  assign ev_wr_final = (st == ST_DIV_FINAL);
  assign settle_en   = (st == ST_SETTLE);
  assign wait_en     = (st == ST_WAIT);
  assign ev_timeout  = wait_en && !lock && wait_hit;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:      if (start) st_nx = ST_DIV_SAFE;
      ST_DIV_SAFE:  st_nx = ST_MUL;
      ST_MUL:       st_nx = ST_SETTLE;
      ST_SETTLE:    if (settle_hit) st_nx = ST_WAIT;
      ST_WAIT: begin
        if (lock)            st_nx = ST_DIV_FINAL;
        else if (ev_timeout) st_nx = ST_IDLE;
      end
      ST_DIV_FINAL: st_nx = ST_IDLE;
      default:      st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      st   <= st_nx;
      done <= ev_wr_final;
      if (ev_accept)       err <= 1'b0;
      else if (ev_timeout) err <= 1'b1;
    end
  end
endmodule

// File: rtl/pll_seq_fields.sv
module pll_seq_fields
  import pll_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_accept,
  input  logic              ev_wr_safe,
  input  logic              ev_wr_mul,
  input  logic              ev_wr_final,
  input  logic [CODE_W-1:0] req_mul,
  input  logic [CODE_W-1:0] req_div,
  output logic [CODE_W-1:0] tgt_mul,
  output logic [CODE_W-1:0] tgt_div,
  output logic [CODE_W-1:0] mul_code,
  output logic [CODE_W-1:0] div_code
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_mul <= MUL_RST;
      tgt_div <= DIV_RST;
    end else if (ev_accept) begin
      tgt_mul <= req_mul;
      tgt_div <= req_div;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mul_code <= MUL_RST;
    else if (ev_wr_mul) mul_code <= tgt_mul;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           div_code <= DIV_RST;
    else if (ev_wr_safe)  div_code <= safe_div(tgt_div);
    else if (ev_wr_final) div_code <= tgt_div;
  end
endmodule

// File: rtl/pll_retune_seq.sv
module pll_retune_seq
  import pll_seq_pkg::*;
#(
  parameter int SETTLE_CYC = 16,
  parameter int TMO_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] req_mul,
  input  logic [CODE_W-1:0] req_div,
  input  logic [TMO_W-1:0]  tmo_limit,
  input  logic              lock,
  output logic [CODE_W-1:0] mul_code,
  output logic [CODE_W-1:0] div_code,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam logic [SW-1:0] SETTLE_LIM = SW'(SETTLE_CYC);

  logic settle_en, wait_en, settle_hit, wait_hit;
  logic ev_accept, ev_wr_safe, ev_wr_mul, ev_wr_final, ev_timeout;
  logic [CODE_W-1:0] tgt_mul, tgt_div;

  pll_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .lock(lock),
    .settle_hit(settle_hit), .wait_hit(wait_hit),
    .settle_en(settle_en), .wait_en(wait_en),
    .ev_accept(ev_accept), .ev_wr_safe(ev_wr_safe), .ev_wr_mul(ev_wr_mul),
    .ev_wr_final(ev_wr_final), .ev_timeout(ev_timeout),
    .busy(busy), .done(done), .err(err)
  );

  pll_seq_counter #(.W(SW)) u_settle (
    .clk(clk), .rst_n(rst_n), .en(settle_en), .limit(SETTLE_LIM), .hit(settle_hit)
  );

  pll_seq_counter #(.W(TMO_W)) u_wait (
    .clk(clk), .rst_n(rst_n), .en(wait_en), .limit(tmo_limit), .hit(wait_hit)
  );

  pll_seq_fields u_fields (
    .clk(clk), .rst_n(rst_n),
    .ev_accept(ev_accept), .ev_wr_safe(ev_wr_safe), .ev_wr_mul(ev_wr_mul),
    .ev_wr_final(ev_wr_final), .req_mul(req_mul), .req_div(req_div),
    .tgt_mul(tgt_mul), .tgt_div(tgt_div),
    .mul_code(mul_code), .div_code(div_code)
  );
endmodule

// File: rtl/pll_retune_seq_chk.sv
module pll_retune_seq_chk
  import pll_seq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              lock,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [CODE_W-1:0] mul_code,
  input logic [CODE_W-1:0] div_code,
  input logic [CODE_W-1:0] tgt_mul,
  input logic [CODE_W-1:0] tgt_div,
  input logic              ev_accept,
  input logic              ev_wr_safe,
  input logic              ev_wr_mul,
  input logic              ev_wr_final,
  input logic              ev_timeout
);
  a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> busy);

  a_r3_safe_div: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_safe |=> (div_code == safe_div($past(tgt_div))) && $stable(mul_code));

  a_r4_mul_write: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_mul |=> (mul_code == $past(tgt_mul)) && $stable(div_code));

  a_r6_final_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_final |-> $past(lock));

  a_r6_final_value: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_final |=> (div_code == $past(tgt_div)) && !busy);

  a_r7_ignore_start: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(tgt_mul) && $stable(tgt_div));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |=> err && !busy && !done && $stable(div_code));

  a_r3_one_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_wr_safe, ev_wr_mul, ev_wr_final}));
endmodule

bind pll_retune_seq pll_retune_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .lock(lock),
  .busy(busy), .done(done), .err(err),
  .mul_code(mul_code), .div_code(div_code),
  .tgt_mul(tgt_mul), .tgt_div(tgt_div),
  .ev_accept(ev_accept), .ev_wr_safe(ev_wr_safe), .ev_wr_mul(ev_wr_mul),
  .ev_wr_final(ev_wr_final), .ev_timeout(ev_timeout)
);

// File: tb/pll_retune_seq_test.sv
module pll_retune_seq_test;
  localparam int S  = 5;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] req_mul = '0, req_div = '0;
  logic [TW-1:0] tmo_limit = 8'd200;
  logic lock = 1'b0;
  logic [2:0] mul_code, div_code;
  logic busy, done, err;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pll_retune_seq #(.SETTLE_CYC(S), .TMO_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_mul(req_mul), .req_div(req_div),
    .tmo_limit(tmo_limit), .lock(lock), .mul_code(mul_code), .div_code(div_code),
    .busy(busy), .done(done), .err(err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int slow_code(input int d);
    int n = d + 1;
    return (n > 7) ? 7 : n;
  endfunction

  // leaves the bench at the falling edge just after the accepting edge
  task automatic kick(input int m, input int d);
    @(negedge clk);
    start = 1'b1; req_mul = 3'(m); req_div = 3'(d);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 mul_code", mul_code, 0);
    chk("R1 div_code", div_code, 1);
    chk("R1 ratio x2", (2 * (mul_code + 2)) / (1 << div_code), 2);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 err", err, 0);
  endtask

  task automatic t_normal(input int m, input int d);
    int prev_div = div_code;
    int prev_mul = mul_code;
    lock = 1'b1;
    kick(m, d);
    chk("R2 busy after accept", busy, 1);
    chk("R2 div untouched yet", div_code, prev_div);
    @(negedge clk);
    chk("R3 safe divider", div_code, slow_code(d));
    chk("R3 mul unchanged", mul_code, prev_mul);
    @(negedge clk);
    chk("R4 mul written", mul_code, m);
    chk("R4 div still safe", div_code, slow_code(d));
    repeat (S + 1) @(negedge clk);
    chk("R5 no early final write", div_code, slow_code(d));
    chk("R5 still busy", busy, 1);
    chk("R8 no early done", done, 0);
    @(negedge clk);
    chk("R5 final write at S+2", div_code, d);
    chk("R8 done high", done, 1);
    chk("R6 busy falls", busy, 0);
    @(negedge clk);
    chk("R8 done single cycle", done, 0);
  endtask

  task automatic t_late_lock();
    lock = 1'b0; tmo_limit = 8'd200;
    kick(3, 0);
    @(negedge clk);
    chk("R3 safe from 0", div_code, 1);
    @(negedge clk);
    chk("R4 mul 3", mul_code, 3);
    repeat (12) @(negedge clk);
    chk("R6 waiting keeps safe div", div_code, 1);
    chk("R6 waiting busy", busy, 1);
    lock = 1'b1;
    @(negedge clk);
    chk("R6 one edge after lock", div_code, 1);
    @(negedge clk);
    chk("R6 final div", div_code, 0);
    chk("R8 done late lock", done, 1);
  endtask

  task automatic t_ignore_start();
    int dones = 0;
    lock = 1'b1;
    kick(1, 3);
    start = 1'b1; req_mul = 3'd6; req_div = 3'd6;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk("R7 mul kept first request", mul_code, 1);
    for (int i = 0; i < 40 && busy; i++) begin
      @(negedge clk);
      if (done) dones++;
    end
    chk("R7 final div of first request", div_code, 3);
    chk("R7 one done", dones, 1);
    repeat (3) @(negedge clk);
    chk("R7 nothing queued", busy, 0);
    chk("R7 mul stays", mul_code, 1);
  endtask

  task automatic t_timeout();
    lock = 1'b0; tmo_limit = 8'd6;
    kick(2, 4);
    @(negedge clk);
    @(negedge clk);
    chk("R4 mul 2", mul_code, 2);
    repeat (S + 6 - 1) @(negedge clk);
    chk("R9 busy before limit", busy, 1);
    chk("R9 no err before limit", err, 0);
    @(negedge clk);
    chk("R9 busy cleared", busy, 0);
    chk("R9 err set", err, 1);
    chk("R9 div left safe", div_code, 5);
    chk("R9 mul kept", mul_code, 2);
    chk("R9 no done", done, 0);
    lock = 1'b1; tmo_limit = 8'd200;
    kick(4, 1);
    chk("R9 err cleared by start", err, 0);
    for (int i = 0; i < 40 && busy; i++) @(negedge clk);
    chk("R9 recovery final div", div_code, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_normal(5, 2);
    t_normal(6, 7);   // R3 saturation at 7
    t_late_lock();
    t_ignore_start();
    t_timeout();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule